// File: doc/BRIEF.md
# Transmit Descriptor Ring DMA Engine

This block moves outgoing frames from memory to a MAC. Software builds a ring of descriptors in memory. Each descriptor is three 32-bit words: a control word, a length word and a buffer address. Software hands a descriptor over by setting its ownership flag, then sets a run bit in the block's register port. The engine reads the descriptor and fetches the buffer as whole 32-bit words. It sends the bytes, least significant byte first, on a byte-wide valid/ready stream. When the frame is done, it writes the control word back with the ownership flag cleared, so software can poll for completion.

The ring has no fixed depth. A flag inside a descriptor marks the end of the ring, and after that descriptor the engine goes back to the ring base. Otherwise it moves on 12 bytes. When the engine reads a descriptor that software has not handed over, it clears its own run bit and waits. Software restarts it by setting the run bit again, and processing resumes at that same descriptor. CRC, padding and the MAC itself are outside this block.

Control word layout: bit 31 is ownership (set means the engine owns the descriptor), bit 30 is end-of-ring, bit 29 is frame start and bit 28 is frame end. The frame byte count is bits 31:16 of the length word. The register port has two registers. Select 0 is the ring base address. Select 1 holds the run bit in bit 0.

Top module: `txring_dma`

## Requirements
- R1: After a synchronous active-low reset, the ring base register and the run bit read 0, `tx_valid` is low and `mem_req` is low.
- R2: A running engine reads the control word at the current descriptor address, then the length word at +4, then the buffer address at +8. The byte count is taken from bits 31:16 of the length word only, and bits 15:0 are ignored.
- R3: Buffer bytes leave on the stream in address order. Each 32-bit word is read from a 4-byte-aligned buffer address and emitted little-endian, bits 7:0 first.
- R4: The final word of a frame yields only the remaining (length mod 4) bytes, or 4 if that is zero. A zero-length descriptor emits no byte and reads no buffer word.
- R5: `tx_last` is high on the final byte of a descriptor exactly when control bit 28 (frame end) is set, and is low on every other byte.
- R6: After the last byte, the engine writes the stored control word back to the descriptor address with bit 31 cleared. Every other bit, including end-of-ring bit 30, is unchanged.
- R7: The next descriptor is at the current address + 12, or at the ring base if bit 30 of the current control word is set.
- R8: Reading a control word with bit 31 clear clears the run bit (select 1, bit 0) and idles the engine without changing the current address. Setting the run bit again resumes at that descriptor.
- R9: A write to the base register (select 0) is ignored while the run bit is set or the engine is busy. A write while idle updates the base and moves the current descriptor address to it.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_data` and `tx_last` hold their values.
- R11: The memory request is held with a stable address and direction until `mem_ack`, and every memory address is word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 ring base, 1 run control |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Read data of the selected register |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | AW | Memory byte address, word aligned |
| mem_wdata | output | 32 | Write data (descriptor writeback) |
| mem_ack | input | 1 | Access complete; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of a frame |
| tx_ready | input | 1 | Stream sink ready |

## Verification
Each memory access finishes at the clock edge where `mem_ack` is sampled high. The first byte of a fetched word appears on the stream one edge later. The run bit shows in the readback one edge after its write, and it clears one edge after the ack of a control word that has ownership clear. The model memory in the bench answers with a different latency in each case, so the bench does not count a fixed number of cycles. It polls the run-bit readback half a cycle after each edge. Stream bytes are taken at the falling edge after `tx_ready` has been driven, which is the handshake committed at the next rising edge. Writeback words are compared only after the run bit is seen clear, which is later than the descriptor's writeback ack.

// File: rtl/txr_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the transmit descriptor ring engine.
// Assumes 32-bit descriptor words and a 16-bit byte count field.
package txr_pkg;
    localparam int DESC_WORDS = 3;     // words per descriptor (stride 12 bytes)
    localparam int OWN_BIT    = 31;    // engine owns descriptor
    localparam int RING_END_B = 30;    // last descriptor in ring
    localparam int FEND_BIT   = 28;    // buffer closes a frame
    localparam int CNT_W      = 16;    // byte count width
    localparam int CNT_LSB    = 16;    // byte count position in length word

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTL,
        ST_LEN,
        ST_BUF,
        ST_FETCH,
        ST_SEND,
        ST_WB
    } eng_state_t;
endpackage

// File: rtl/txr_regs.sv
`timescale 1ns/1ps
// Register port: ring base address and run bit.
// Assumes one access per cycle; a base write is taken only while the
// engine is idle and not requested to run. A set request wins over the
// engine's own stop in the same cycle.
module txr_regs #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          sel,
    input  logic [AW-1:0] wdata,
    input  logic          eng_busy,
    input  logic          stop_req,
    output logic [AW-1:0] base_q,
    output logic          run_q,
    output logic          base_ld,
    output logic [AW-1:0] rdata
);
    logic run_set;

    // Decode the accepted writes.
    always_comb begin
        base_ld = wr && !sel && !run_q && !eng_busy;
        run_set = wr && sel && wdata[0];
    end

    // Ring base register.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= '0;
        else if (base_ld) base_q <= wdata;
    end

    // Run bit: set by software, cleared by the engine.
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= 1'b0;
        else if (run_set)  run_q <= 1'b1;
        else if (stop_req) run_q <= 1'b0;
    end

    // Readback multiplexer.
    always_comb begin
        rdata = sel ? {{(AW-1){1'b0}}, run_q} : base_q;
    end
endmodule

// File: rtl/txr_unpack.sv
`timescale 1ns/1ps
// Word-to-byte serializer: holds one 32-bit word and emits 1..4 bytes,
// low byte first, on a valid/ready stream. Marks the final byte of a
// frame when the word is the last one and the frame-end flag is set.
// Assumes a new word is loaded only after the previous one drained.
module txr_unpack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ld,
    input  logic [31:0] word_in,
    input  logic [2:0]  nbytes_in,
    input  logic        lastw_in,
    input  logic        fend_in,
    input  logic        tx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_last,
    output logic        done
);
    logic [31:0] sh_q;
    logic [2:0]  cnt_q;
    logic        lastw_q;
    logic        fend_q;
    logic        fire;

    // Stream outputs from the holding register.
    always_comb begin
        tx_valid = (cnt_q != 3'd0);
        tx_data  = sh_q[7:0];
        tx_last  = tx_valid && lastw_q && fend_q && (cnt_q == 3'd1);
        fire     = tx_valid && tx_ready;
        done     = fire && (cnt_q == 3'd1);
    end

    // Load a word or shift out one byte per handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            cnt_q   <= '0;
            lastw_q <= 1'b0;
            fend_q  <= 1'b0;
        end else if (ld) begin
            sh_q    <= word_in;
            cnt_q   <= nbytes_in;
            lastw_q <= lastw_in;
            fend_q  <= fend_in;
        end else if (fire) begin
            sh_q    <= {8'h00, sh_q[31:8]};
            cnt_q   <= cnt_q - 3'd1;
        end
    end
endmodule

// File: rtl/txr_ctrl.sv
`timescale 1ns/1ps
// Descriptor walker: fetches the three descriptor words, reads the
// buffer word by word into the serializer, writes the control word back
// with ownership cleared, and advances or wraps the current pointer.
// Assumes one memory access in flight, held until acknowledged; read data
// is valid in the acknowledge cycle. Pointers are word addresses.
module txr_ctrl
    import txr_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [AW-3:0] base_ptr,
    input  logic          base_ld,
    input  logic [AW-3:0] ld_ptr,
    output logic          stop_req,
    output logic          busy,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          unp_ld,
    output logic [2:0]    unp_nbytes,
    output logic          unp_lastw,
    output logic          unp_fend,
    input  logic          unp_done
);
    localparam int PW = AW - 2;

    eng_state_t        st_q, st_d;
    logic [PW-1:0]     cur_q;
    logic [PW-1:0]     bufp_q;
    logic [31:0]       ctl_q;
    logic [CNT_W-1:0]  remain_q;
    logic [PW-1:0]     acc_ptr;
    logic [PW-1:0]     next_desc;

    // Memory request decode from the current state.
    always_comb begin
        mem_req = 1'b0;
        mem_we  = 1'b0;
        acc_ptr = cur_q;
        unique case (st_q)
            ST_CTL:   begin mem_req = 1'b1; acc_ptr = cur_q; end
            ST_LEN:   begin mem_req = 1'b1; acc_ptr = cur_q + PW'(1); end
            ST_BUF:   begin mem_req = 1'b1; acc_ptr = cur_q + PW'(2); end
            ST_FETCH: begin mem_req = 1'b1; acc_ptr = bufp_q; end
            ST_WB:    begin mem_req = 1'b1; mem_we = 1'b1; acc_ptr = cur_q; end
            default:  ;
        endcase
        mem_addr  = {acc_ptr, 2'b00};
        mem_wdata = {1'b0, ctl_q[30:0]};
    end

    // Byte count and last-word decode for the word being fetched.
    always_comb begin
        unp_nbytes = (remain_q >= CNT_W'(4)) ? 3'd4 : {1'b0, remain_q[1:0]};
        unp_lastw  = (remain_q <= CNT_W'(4));
        unp_fend   = ctl_q[FEND_BIT];
        unp_ld     = (st_q == ST_FETCH) && mem_ack;
        stop_req   = (st_q == ST_CTL) && mem_ack && !mem_rdata[OWN_BIT];
        busy       = (st_q != ST_IDLE);
        next_desc  = ctl_q[RING_END_B] ? base_ptr : cur_q + PW'(DESC_WORDS);
    end

    // Next-state logic of the descriptor walk.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (run) st_d = ST_CTL;
            ST_CTL:   if (mem_ack) st_d = mem_rdata[OWN_BIT] ? ST_LEN : ST_IDLE;
            ST_LEN:   if (mem_ack) st_d = ST_BUF;
            ST_BUF:   if (mem_ack) st_d = (remain_q == '0) ? ST_WB : ST_FETCH;
            ST_FETCH: if (mem_ack) st_d = ST_SEND;
            ST_SEND:  if (unp_done) st_d = (remain_q == '0) ? ST_WB : ST_FETCH;
            ST_WB:    if (mem_ack) st_d = ST_CTL;
            default:  st_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Current descriptor pointer: load from base, advance or wrap after writeback.
    always_ff @(posedge clk) begin
        if (!rst_n)                           cur_q <= '0;
        else if (base_ld)                     cur_q <= ld_ptr;
        else if ((st_q == ST_WB) && mem_ack)  cur_q <= next_desc;
    end

    // Descriptor fields captured from the read words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            remain_q <= '0;
            bufp_q   <= '0;
        end else if (mem_ack) begin
            unique case (st_q)
                ST_CTL:   ctl_q    <= mem_rdata;
                ST_LEN:   remain_q <= mem_rdata[CNT_LSB +: CNT_W];
                ST_BUF:   bufp_q   <= mem_rdata[AW-1:2];
                ST_FETCH: begin
                    remain_q <= remain_q - CNT_W'(unp_nbytes);
                    bufp_q   <= bufp_q + PW'(1);
                end
                default:  ;
            endcase
        end
    end
endmodule

// File: rtl/txring_dma.sv
`timescale 1ns/1ps
// Transmit descriptor ring DMA engine, top level. Connects the register
// port, the descriptor walker and the byte serializer.
// Assumes AW <= 32 and word-aligned descriptors and buffers.
module txring_dma #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [AW-1:0] reg_wdata,
    output logic [AW-1:0] reg_rdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic          mem_ack,
    input  logic [31:0]   mem_rdata,
    output logic          tx_valid,
    output logic [7:0]    tx_data,
    output logic          tx_last,
    input  logic          tx_ready
);
    logic [AW-1:0] base_q;
    logic          run_q;
    logic          base_ld;
    logic          stop_req;
    logic          busy;
    logic          unp_ld;
    logic [2:0]    unp_nbytes;
    logic          unp_lastw;
    logic          unp_fend;
    logic          unp_done;

    txr_regs #(.AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .sel      (reg_sel),
        .wdata    (reg_wdata),
        .eng_busy (busy),
        .stop_req (stop_req),
        .base_q   (base_q),
        .run_q    (run_q),
        .base_ld  (base_ld),
        .rdata    (reg_rdata)
    );

    txr_ctrl #(.AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run_q),
        .base_ptr   (base_q[AW-1:2]),
        .base_ld    (base_ld),
        .ld_ptr     (reg_wdata[AW-1:2]),
        .stop_req   (stop_req),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .unp_ld     (unp_ld),
        .unp_nbytes (unp_nbytes),
        .unp_lastw  (unp_lastw),
        .unp_fend   (unp_fend),
        .unp_done   (unp_done)
    );

    txr_unpack u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld        (unp_ld),
        .word_in   (mem_rdata),
        .nbytes_in (unp_nbytes),
        .lastw_in  (unp_lastw),
        .fend_in   (unp_fend),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_data   (tx_data),
        .tx_last   (tx_last),
        .done      (unp_done)
    );
endmodule

// File: rtl/txring_dma_chk.sv
`timescale 1ns/1ps
// Protocol checker for the transmit ring engine, bound to the top level.
// Observes only the block's ports.
module txring_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic [31:0]   mem_wdata,
    input logic          mem_ack,
    input logic          tx_valid,
    input logic [7:0]    tx_data,
    input logic          tx_last,
    input logic          tx_ready
);
    // Outputs are quiet in the cycle after reset is sampled.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!tx_valid && !mem_req));

    // Stalled stream byte holds.
    assert_stream_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

    // Memory request holds until acknowledged.
    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // Memory addresses are word aligned.
    assert_addr_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00));

    // Writeback releases ownership.
    assert_wb_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[31]);

    // The frame marker only rides on a valid byte.
    assert_last_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_last |-> tx_valid);
endmodule

bind txring_dma txring_dma_chk #(.AW(AW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ack   (mem_ack),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .tx_last   (tx_last),
    .tx_ready  (tx_ready)
);

// File: tb/tb_txring_dma.sv
`timescale 1ns/1ps
// Bench: model memory with variable latency, stream sink with several
// ready patterns, and a sweep of frame lengths and ring layouts.
module tb_txring_dma;
    localparam int AW = 32;
    localparam logic [31:0] OWN  = 32'h8000_0000;
    localparam logic [31:0] REND = 32'h4000_0000;
    localparam logic [31:0] FST  = 32'h2000_0000;
    localparam logic [31:0] FEND = 32'h1000_0000;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_wr;
    logic          reg_sel;
    logic [AW-1:0] reg_wdata;
    logic [AW-1:0] reg_rdata;
    logic          mem_req;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic          mem_ack;
    logic [31:0]   mem_rdata;
    logic          tx_valid;
    logic [7:0]    tx_data;
    logic          tx_last;
    logic          tx_ready;

    always #2.5 clk = ~clk;

    txring_dma #(.AW(AW)) dut (.*);

    logic [31:0] mem [0:255];
    int lat, rmode, wcnt, phase, misalign;
    int vec, bad;
    logic [7:0] cap_d [0:511];
    logic       cap_l [0:511];
    int         cap_n;
    logic [7:0] exp_d [0:511];
    logic       exp_l [0:511];
    int         exp_n;

    // Memory responder and stream sink, both acting at the falling edge.
    initial begin
        mem_ack = 1'b0; mem_rdata = '0; tx_ready = 1'b0;
        wcnt = 0; phase = 0; misalign = 0; cap_n = 0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0; wcnt = 0;
            end else if (mem_req) begin
                if (wcnt >= lat) begin
                    mem_ack = 1'b1;
                    if (mem_addr[1:0] != 2'b00) misalign++;
                    if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
                    else        mem_rdata = mem[mem_addr[9:2]];
                end else wcnt++;
            end
            phase++;
            tx_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? phase[0] : 1'b0;
            #1;
            if (tx_valid && tx_ready && cap_n < 512) begin
                cap_d[cap_n] = tx_data; cap_l[cap_n] = tx_last; cap_n++;
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(150000 * 5);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic wr_reg(input logic s, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic s, output logic [31:0] d);
        @(negedge clk);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] d;
        int n = 0;
        do begin
            rd_reg(1'b1, d);
            n++;
        end while (d[0] && n < 4000);
        chk(n < 4000, tag, d, 32'h0);
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((seed * 29 + k * 13 + 7) & 255);
    endfunction

    // Place a descriptor; the length word carries junk in its low half.
    task automatic put_desc(input int w, input logic [31:0] ctl, input int len, input logic [31:0] bufa);
        mem[w]     = ctl;
        mem[w + 1] = {16'(len), 16'hBEEF};
        mem[w + 2] = bufa;
    endtask

    // Fill a buffer and append its expected bytes to the stream model.
    task automatic expect_buf(input logic [31:0] bufa, input int len, input int seed, input bit fe);
        for (int k = 0; k < len; k++) begin
            int wi = int'(bufa[9:2]) + k / 4;
            int bi = k % 4;
            mem[wi][bi*8 +: 8] = pat(seed, k);
            exp_d[exp_n] = pat(seed, k);
            exp_l[exp_n] = fe && (k == len - 1);
            exp_n++;
        end
    endtask

    task automatic clr_stream();
        cap_n = 0; exp_n = 0;
    endtask

    task automatic chk_stream(input string tag);
        chk(cap_n == exp_n, {tag, " byte count"}, cap_n, exp_n);
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            chk(cap_d[i] == exp_d[i], {tag, " data"}, cap_d[i], exp_d[i]);
            chk(cap_l[i] == exp_l[i], {tag, " last"}, 32'(cap_l[i]), 32'(exp_l[i]));
        end
    endtask

    initial begin
        logic [31:0] d, ctl0, ctl1, ctl2;
        logic [7:0]  hold_d;
        vec = 0; bad = 0; lat = 0; rmode = 0; exp_n = 0;
        rst_n = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (3) @(negedge clk);

        // R1: reset state
        rd_reg(1'b0, d); chk(d == 32'h0, "R1 base after reset", d, 32'h0);
        rd_reg(1'b1, d); chk(d == 32'h0, "R1 run after reset", d, 32'h0);
        chk(!tx_valid, "R1 tx_valid", 32'(tx_valid), 32'h0);
        chk(!mem_req, "R1 mem_req", 32'(mem_req), 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R9: base write while idle
        wr_reg(1'b0, 32'h100);
        rd_reg(1'b0, d); chk(d == 32'h100, "R9 idle base write", d, 32'h100);

        // R2 R3 R4 R5 R6 R7 R8: single-descriptor ring, lengths 0..9
        for (int len = 0; len < 10; len++) begin
            bit fe = (len != 7) && (len != 2);
            logic [31:0] bufa = 32'h200 + 32'(len * 16);
            lat = len % 3; rmode = len % 2;
            clr_stream();
            ctl0 = OWN | REND | FST | (fe ? FEND : 32'h0) | (32'h0A50 + 32'(len));
            put_desc(64, ctl0, len, bufa);
            expect_buf(bufa, len, len, fe);
            wr_reg(1'b1, 32'h1);
            wait_idle("R8 sweep stop");
            chk_stream("R2 R3 R4 R5 sweep");
            chk(mem[64] == (ctl0 & ~OWN), "R6 sweep writeback", mem[64], ctl0 & ~OWN);
            rd_reg(1'b1, d); chk(d == 32'h0, "R8 run cleared", d, 32'h0);
        end

        // R7 R5: three-slot ring, two owned, frame-end only on the first
        lat = 1; rmode = 1; clr_stream();
        ctl0 = OWN | FST | FEND | 32'h11;
        ctl1 = OWN | FST | 32'h22;
        ctl2 = REND | 32'h33;
        put_desc(64, ctl0, 5, 32'h300);
        put_desc(67, ctl1, 3, 32'h320);
        put_desc(70, ctl2, 6, 32'h340);
        expect_buf(32'h300, 5, 20, 1'b1);
        expect_buf(32'h320, 3, 21, 1'b0);
        wr_reg(1'b1, 32'h1);
        wait_idle("R8 ring stop");
        chk_stream("R7 R5 ring walk");
        chk(mem[64] == (ctl0 & ~OWN), "R6 slot0 writeback", mem[64], ctl0 & ~OWN);
        chk(mem[67] == (ctl1 & ~OWN), "R6 slot1 writeback", mem[67], ctl1 & ~OWN);
        chk(mem[70] == ctl2, "R8 unowned slot untouched", mem[70], ctl2);

        // R8 R7: resume at the unowned slot after arming it
        clr_stream();
        ctl2 = OWN | REND | FST | FEND | 32'h33;
        mem[70] = ctl2;
        expect_buf(32'h340, 6, 22, 1'b1);
        wr_reg(1'b1, 32'h1);
        wait_idle("R8 resume stop");
        chk_stream("R8 R7 resume at slot2");
        chk(mem[70] == (ctl2 & ~OWN), "R6 end flag kept", mem[70], ctl2 & ~OWN);

        // R7: after the ring-end slot the walk returns to the base
        clr_stream(); lat = 2; rmode = 0;
        ctl0 = OWN | REND | FST | FEND | 32'h44;
        put_desc(64, ctl0, 2, 32'h360);
        expect_buf(32'h360, 2, 23, 1'b1);
        wr_reg(1'b1, 32'h1);
        wait_idle("R7 wrap stop");
        chk_stream("R7 wrap to base");

        // R9 R10: base write ignored during a stalled transfer
        clr_stream(); lat = 0; rmode = 2;
        ctl0 = OWN | REND | FST | FEND | 32'h55;
        put_desc(64, ctl0, 9, 32'h380);
        expect_buf(32'h380, 9, 30, 1'b1);
        wr_reg(1'b1, 32'h1);
        repeat (20) @(negedge clk);
        #1;
        chk(tx_valid, "R10 stalled valid", 32'(tx_valid), 32'h1);
        hold_d = tx_data;
        repeat (3) @(negedge clk);
        #1;
        chk(tx_data == hold_d, "R10 stalled data holds", tx_data, hold_d);
        wr_reg(1'b0, 32'h180);
        rd_reg(1'b0, d); chk(d == 32'h100, "R9 base write while running", d, 32'h100);
        rmode = 0;
        wait_idle("R9 busy stop");
        chk_stream("R9 R10 stalled frame");
        rd_reg(1'b0, d); chk(d == 32'h100, "R9 base after run", d, 32'h100);

        // R9: idle base write moves the current descriptor
        wr_reg(1'b0, 32'h180);
        rd_reg(1'b0, d); chk(d == 32'h180, "R9 new base", d, 32'h180);
        clr_stream(); lat = 1;
        ctl1 = OWN | REND | FST | FEND | 32'h66;
        put_desc(96, ctl1, 4, 32'h3A0);
        expect_buf(32'h3A0, 4, 40, 1'b1);
        wr_reg(1'b1, 32'h1);
        wait_idle("R9 new ring stop");
        chk_stream("R9 R4 new ring");
        chk(mem[96] == (ctl1 & ~OWN), "R6 new ring writeback", mem[96], ctl1 & ~OWN);

        // R11: all addresses seen by memory were word aligned
        chk(misalign == 0, "R11 aligned accesses", misalign, 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule